// File: doc/BRIEF.md
# UART Receive Interrupt Condition Generator

This block sits beside a 16-entry UART receive FIFO and decides when the receive side should raise an interrupt. It does not store data or deserialize bits. It watches the FIFO occupancy, a pulse for each character that the shift register pushes into the FIFO, and a CPU read strobe. From these and the programmed frame format it produces three registered indications:

- a data-ready flag,
- a request raised when the occupancy reaches a programmed trigger threshold,
- a character-timeout request.

The timeout exists so that a few characters left below the threshold are not stranded. It measures silence in receive baud-clock enables, which run at sixteen per bit. The delay therefore follows the baud rate and the programmed frame length. The receive FIFO mode bit and the receive interrupt enable bit together gate both requests. The interrupt priority encoder that consumes these requests is a separate block.

Top module: `uart_rx_irq_timer`

## Requirements
- R1: The data-available request is high one clock after a cycle in which both enables are 1 and the occupancy is at or above the threshold. The 2-bit trigger select maps 0, 1, 2 and 3 to thresholds of 1, 4, 8 and 14 characters.
- R2: The data-available request is low one clock after any cycle in which the occupancy is below the selected threshold.
- R3: The data-ready flag goes high one clock after a push pulse. It stays high while the occupancy is nonzero. It goes low one clock after a cycle with zero occupancy and no push.
- R4: The limit is 64 × (7 + W + P + S) baud ticks. W is the word-length code, where 0 to 3 means 5 to 8 data bits. P is the parity-enable bit and S is the two-stop-bit select. With occupancy nonzero, the timeout request rises one clock after the limit-th baud tick that follows the last restart, and not earlier.
- R5: Selecting two stop bits adds one bit time, 16 ticks per character, to each character time in R4.
- R6: While the occupancy is zero, the timer holds at zero, and the timeout request is low one clock later.
- R7: A push while no timeout is pending restarts the timer. A full limit of ticks is then needed again.
- R8: A CPU read clears a pending timeout on the next clock and restarts the timer.
- R9: A push while a timeout is pending leaves the request high.
- R10: If either the FIFO-enable bit or the receive-interrupt-enable bit is 0, both requests are low one clock later and the timer holds at zero.
- R11: A push and a CPU read in the same cycle act as a read: a pending timeout clears and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_count | input | 5 | Receive FIFO occupancy, 0 to 16 |
| char_push | input | 1 | One-cycle pulse per character entering the FIFO |
| cpu_rd | input | 1 | One-cycle pulse per CPU read of the FIFO |
| trig_sel | input | 2 | Trigger threshold select |
| word_len | input | 2 | Data bits code, 0 to 3 means 5 to 8 |
| parity_en | input | 1 | Parity bit present in frame |
| two_stop | input | 1 | Frame carries a second stop bit |
| baud_tick | input | 1 | Clock enable at 16 times the bit rate |
| fifo_en | input | 1 | Receive FIFO mode enabled |
| rx_ie | input | 1 | Receive interrupt enable |
| data_ready | output | 1 | At least one character is waiting |
| data_avail_req | output | 1 | Occupancy at or above trigger threshold |
| timeout_req | output | 1 | Character timeout pending |

## Verification
The timer can see a character push and a CPU read in the same cycle. A push can also arrive while a timeout is already pending. The bench first drives the timer to a pending timeout. It then presents a push alone, and later a push together with a read. It checks that the lone push leaves the request high. It checks that the combined pulse drops the request on the next clock and that exactly a full limit of ticks is then needed before it returns. It also sweeps all sixteen frame formats and all trigger and occupancy pairs, and compares against counts worked out by arithmetic.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;

    localparam int FIFO_DEPTH    = 16;
    localparam int CNT_W         = $clog2(FIFO_DEPTH + 1);
    localparam int OVS           = 16;
    localparam int TO_CHARS      = 4;
    localparam int MAX_CHAR_BITS = 12;
    localparam int LIMIT_W       = $clog2(TO_CHARS * OVS * MAX_CHAR_BITS + 1);

    typedef logic [CNT_W-1:0]   occ_t;
    typedef logic [LIMIT_W-1:0] tick_t;

    typedef enum logic [1:0] {WLEN_5, WLEN_6, WLEN_7, WLEN_8} wlen_e;
    typedef enum logic [1:0] {TRIG_1, TRIG_4, TRIG_8, TRIG_14} trig_e;

    typedef struct packed {
        wlen_e wlen;
        logic  parity;
        logic  two_stop;
    } frame_cfg_t;

    typedef struct packed {
        logic ready;
        logic avail;
        logic timeout;
    } rx_req_t;

    // start + first stop + 5..8 data + optional parity + optional second stop
    function automatic int frame_bits(frame_cfg_t c);
        return 2 + 5 + int'(c.wlen) + int'(c.parity) + int'(c.two_stop);
    endfunction

    function automatic tick_t timeout_limit(frame_cfg_t c);
        return tick_t'(TO_CHARS * OVS * frame_bits(c));
    endfunction

    function automatic occ_t trig_threshold(trig_e t);
        case (t)
            TRIG_1:  return occ_t'(1);
            TRIG_4:  return occ_t'(4);
            TRIG_8:  return occ_t'(8);
            default: return occ_t'(FIFO_DEPTH - 2);
        endcase
    endfunction

endpackage

// File: rtl/rx_char_time.sv
module rx_char_time
    import rxirq_pkg::*;
(
    input  frame_cfg_t cfg,
    output tick_t      limit
);
    assign limit = timeout_limit(cfg);
endmodule

// File: rtl/rx_level_track.sv
module rx_level_track
    import rxirq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  occ_t  occ,
    input  logic  push,
    input  trig_e trig,
    output logic  ready_q,
    output logic  avail_q
);
    occ_t thr;
    assign thr = trig_threshold(trig);

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
            avail_q <= 1'b0;
        end else begin
            if (push)
                ready_q <= 1'b1;
            else if (occ == '0)
                ready_q <= 1'b0;
            avail_q <= en && (occ >= thr);
        end
    end

    // R3
    ready_set_chk: assert property (@(posedge clk) disable iff (rst)
        push |=> ready_q);
    // R1
    avail_on_chk: assert property (@(posedge clk) disable iff (rst)
        (en && occ >= thr) |=> avail_q);
    // R2
    avail_off_chk: assert property (@(posedge clk) disable iff (rst)
        (occ < thr) |=> !avail_q);
    // R10
    avail_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !avail_q);
endmodule

// File: rtl/rx_timeout_ctr.sv
module rx_timeout_ctr
    import rxirq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  occ_t  occ,
    input  logic  push,
    input  logic  rd,
    input  logic  tick,
    input  tick_t limit,
    output logic  fired_q
);
    tick_t cnt;
    logic  run;
    logic  restart;
    tick_t cnt_inc;

    assign run     = en && (occ != '0);
    assign restart = rd || (push && !fired_q);
    assign cnt_inc = cnt + tick_t'(1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt     <= '0;
            fired_q <= 1'b0;
        end else if (restart) begin
            cnt     <= '0;
            fired_q <= 1'b0;
        end else if (tick && cnt < limit) begin
            cnt <= cnt_inc;
            if (cnt_inc == limit)
                fired_q <= 1'b1;
        end
    end

    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rd |=> !fired_q);
    // R6
    empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |=> !fired_q);
    // R9
    push_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (fired_q && push && !rd && run) |=> fired_q);
    // R10
    to_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !fired_q);
    // R11
    both_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (push && rd) |=> (!fired_q && cnt == '0));
endmodule

// File: rtl/uart_rx_irq_timer.sv
module uart_rx_irq_timer
    import rxirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [4:0] fifo_count,
    input  logic       char_push,
    input  logic       cpu_rd,
    input  logic [1:0] trig_sel,
    input  logic [1:0] word_len,
    input  logic       parity_en,
    input  logic       two_stop,
    input  logic       baud_tick,
    input  logic       fifo_en,
    input  logic       rx_ie,
    output logic       data_ready,
    output logic       data_avail_req,
    output logic       timeout_req
);
    frame_cfg_t cfg;
    tick_t      limit;
    rx_req_t    req;
    logic       en;
    occ_t       occ;

    assign cfg = '{wlen: wlen_e'(word_len), parity: parity_en, two_stop: two_stop};
    assign en  = fifo_en && rx_ie;
    assign occ = occ_t'(fifo_count);

    rx_char_time u_ct (
        .cfg   (cfg),
        .limit (limit)
    );

    rx_level_track u_lvl (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .occ     (occ),
        .push    (char_push),
        .trig    (trig_e'(trig_sel)),
        .ready_q (req.ready),
        .avail_q (req.avail)
    );

    rx_timeout_ctr u_to (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .occ     (occ),
        .push    (char_push),
        .rd      (cpu_rd),
        .tick    (baud_tick),
        .limit   (limit),
        .fired_q (req.timeout)
    );

    assign data_ready     = req.ready;
    assign data_avail_req = req.avail;
    assign timeout_req    = req.timeout;

    // R7
    push_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (char_push && !timeout_req) |=> !timeout_req);
endmodule

// File: tb/sim_uart_rx_irq_timer.sv
module sim_uart_rx_irq_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] fifo_count = '0;
    logic       char_push = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [1:0] trig_sel = '0;
    logic [1:0] word_len = '0;
    logic       parity_en = 1'b0;
    logic       two_stop = 1'b0;
    logic       baud_tick = 1'b0;
    logic       fifo_en = 1'b1;
    logic       rx_ie = 1'b1;
    logic       data_ready, data_avail_req, timeout_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_irq_timer u0 (
        .clk(clk), .rst(rst), .fifo_count(fifo_count), .char_push(char_push),
        .cpu_rd(cpu_rd), .trig_sel(trig_sel), .word_len(word_len),
        .parity_en(parity_en), .two_stop(two_stop), .baud_tick(baud_tick),
        .fifo_en(fifo_en), .rx_ie(rx_ie), .data_ready(data_ready),
        .data_avail_req(data_avail_req), .timeout_req(timeout_req)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ticks(int n);
        baud_tick = 1'b1;
        repeat (n) step();
        baud_tick = 1'b0;
    endtask

    task automatic pulse(logic p, logic r);
        char_push = p;
        cpu_rd    = r;
        step();
        char_push = 1'b0;
        cpu_rd    = 1'b0;
    endtask

    function automatic int exp_thr(int t);
        return (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lim;
        @(negedge clk);
        step();
        step();
        rst = 1'b0;
        step();
        chk("R3 reset ready", data_ready, 1'b0);
        chk("R1 reset avail", data_avail_req, 1'b0);
        chk("R4 reset timeout", timeout_req, 1'b0);

        // R1 / R2: trigger sweep
        for (int t = 0; t < 4; t++) begin
            trig_sel = 2'(t);
            for (int c = 0; c <= 16; c++) begin
                fifo_count = 5'(c);
                step();
                if (c >= exp_thr(t)) chk("R1 avail at level", data_avail_req, 1'b1);
                else                 chk("R2 avail below level", data_avail_req, 1'b0);
            end
        end
        trig_sel = 2'd3;

        // R3: data ready
        fifo_count = 0;
        step();
        char_push = 1'b1;
        step();
        char_push = 1'b0;
        chk("R3 ready on push", data_ready, 1'b1);
        fifo_count = 1;
        step();
        chk("R3 ready holds", data_ready, 1'b1);
        fifo_count = 0;
        step();
        chk("R3 ready clears when empty", data_ready, 1'b0);

        // R4 / R5: every frame format
        fifo_count = 1;
        for (int w = 0; w < 4; w++)
            for (int p = 0; p < 2; p++)
                for (int s = 0; s < 2; s++) begin
                    word_len = 2'(w);
                    parity_en = 1'(p);
                    two_stop = 1'(s);
                    pulse(1'b0, 1'b1);
                    lim = 64 * (7 + w + p + s);
                    ticks(lim - 1);
                    chk(s ? "R5 no timeout one tick early" : "R4 no timeout one tick early",
                        timeout_req, 1'b0);
                    ticks(1);
                    chk(s ? "R5 timeout at limit" : "R4 timeout at limit", timeout_req, 1'b1);
                end

        // R6: empty FIFO
        pulse(1'b0, 1'b1);
        fifo_count = 0;
        ticks(900);
        chk("R6 no timeout when empty", timeout_req, 1'b0);

        // R7: push restarts
        word_len = 2'd3; parity_en = 1'b0; two_stop = 1'b0;
        lim = 640;
        fifo_count = 1;
        pulse(1'b0, 1'b1);
        ticks(500);
        pulse(1'b1, 1'b0);
        ticks(lim - 1);
        chk("R7 push restarted timer", timeout_req, 1'b0);
        ticks(1);
        chk("R7 timeout after full limit", timeout_req, 1'b1);

        // R9: push while pending
        pulse(1'b1, 1'b0);
        chk("R9 push keeps timeout", timeout_req, 1'b1);

        // R8: read clears and restarts
        pulse(1'b0, 1'b1);
        chk("R8 read clears timeout", timeout_req, 1'b0);
        ticks(lim - 1);
        chk("R8 restart needs full limit", timeout_req, 1'b0);
        ticks(1);
        chk("R8 timeout again", timeout_req, 1'b1);

        // R11: push and read together
        pulse(1'b1, 1'b1);
        chk("R11 joint pulse clears", timeout_req, 1'b0);
        ticks(lim - 1);
        chk("R11 joint pulse restarts", timeout_req, 1'b0);
        ticks(1);
        chk("R11 timeout after restart", timeout_req, 1'b1);

        // R10: enable gating
        fifo_en = 1'b0;
        fifo_count = 16;
        step();
        chk("R10 fifo_en off avail", data_avail_req, 1'b0);
        chk("R10 fifo_en off timeout", timeout_req, 1'b0);
        fifo_en = 1'b1;
        rx_ie = 1'b0;
        step();
        chk("R10 rx_ie off avail", data_avail_req, 1'b0);
        ticks(lim + 5);
        chk("R10 rx_ie off timeout", timeout_req, 1'b0);
        rx_ie = 1'b1;
        ticks(lim - 1);
        chk("R10 timer held while disabled", timeout_req, 1'b0);
        ticks(1);
        chk("R10 timeout after enable", timeout_req, 1'b1);
        chk("R1 avail after enable", data_avail_req, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule